// File: doc/BRIEF.md
# Dual-Byte Baud and Frame-Length Timer

This block produces the shift clock for a serial transmitter. Two chained 8-bit down-counters do the work. The low counter divides the module clock into half-bit periods. The high counter counts the half-period toggles until the data part of the frame is done. A single 16-bit compare word sets both: the low byte is the half-period reload and the high byte is the doubled bit count minus one. For example, 0x0F01 gives eight bits at one quarter of the module clock rate.

A frame starts when the effective trigger (the trigger input XOR its polarity select) is high and the timer is idle. This trigger is normally the transmit shifter's buffer-empty flag, inverted. An optional clear-to-send input can also gate the start, and it has its own polarity select. Optional start and stop bit periods add one full bit period each around the data. At the end of the stop bit, or at the end of the data when there is no stop bit, the timer does three things: it raises a sticky status flag, forces its output low, and returns to idle. If the trigger is still high, the timer starts again on the next clock. With the compare function disabled, the frame has no length limit: the timer runs until the enable condition drops, and the status flag is not raised.

The timer output is sent out unchanged as an output trigger. A pin copy of the output has its own inversion control, and that inversion does not affect the output trigger.

Top module: `dual_byte_baud_timer`

## Requirements
- R1: After reset, tmr_out, out_trig, pin_out (with pin_inv=0), stat_flag and active are all 0.
- R2: While active, tmr_out toggles once every cmp_val[7:0]+1 clocks, counted from the clock edge that starts the frame.
- R3: The data part of a frame lasts cmp_val[15:8]+1 half periods, so compare 0x0F01 with no start or stop bit keeps active high for exactly 32 clocks.
- R4: start_bit_en=1 adds two half periods before the data, and stop_bit_en=1 adds two half periods after it.
- R5: An idle timer starts on the clock edge where (trig_in XOR trig_inv)=1 and the CTS condition holds. While the effective trigger is 0 it stays idle.
- R6: With cts_en=1, a start also needs (cts_in XOR cts_inv)=1. With cts_en=0, cts_in and cts_inv have no effect.
- R7: out_trig always equals tmr_out, and pin_out equals tmr_out XOR pin_inv.
- R8: stat_flag goes to 1 on the edge that ends a counted frame. It stays 1 until a cycle with stat_clr=1. A set in the same cycle as a clear takes priority.
- R9: When a frame ends, tmr_out and active are 0 for at least one clock. The next frame starts on the following edge if the enable condition is still true.
- R10: With cmp_dis=1, a frame does not end on the count. It ends on the first edge where the enable condition is false, and stat_flag is not set.
- R11: With cmp_dis=0, dropping the trigger in the middle of a frame does not shorten the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_val | input | 16 | [7:0] half-period reload, [15:8] doubled bit count minus one |
| cmp_dis | input | 1 | 1 = no count-based frame end |
| start_bit_en | input | 1 | Add a start-bit period before the data |
| stop_bit_en | input | 1 | Add a stop-bit period after the data |
| trig_in | input | 1 | Trigger input |
| trig_inv | input | 1 | Trigger polarity select (1 = active low) |
| cts_en | input | 1 | Enable clear-to-send gating of the start |
| cts_in | input | 1 | Clear-to-send pin level |
| cts_inv | input | 1 | CTS polarity select (1 = active low) |
| pin_inv | input | 1 | Inversion of the pin copy only |
| stat_clr | input | 1 | Write-one clear of stat_flag |
| tmr_out | output | 1 | Timer output (shift clock) |
| out_trig | output | 1 | Output trigger, equal to tmr_out |
| pin_out | output | 1 | Pin copy of tmr_out after pin_inv |
| stat_flag | output | 1 | Sticky end-of-frame status |
| active | output | 1 | Timer is running a frame |

## Verification
The assertions check the following on every cycle:
- the reset values;
- that an idle timer keeps its output low;
- that an idle timer does not start while the trigger or the CTS condition is inactive;
- that the flag rises only as a frame ends;
- that the flag holds while no clear is written.

The bench's scenarios are needed for the rest, compared clock by clock against a behavioural model:
- the exact half-period and frame lengths, including the 32-clock frame for 0x0F01;
- the start and stop bit extensions;
- the restart after a frame;
- the compare-disabled run that stops without a flag.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } phase_t;

    typedef struct packed {
        logic fin;
        logic set_flag;
    } frame_end_t;

    function automatic phase_t first_phase(input logic with_start);
        return with_start ? PH_START : PH_DATA;
    endfunction

    function automatic logic effective_level(input logic lvl, input logic inv);
        return lvl ^ inv;
    endfunction
endpackage

// File: rtl/dbt_enable_gate.sv
module dbt_enable_gate
    import dbt_pkg::*;
(
    input  logic trig_in,
    input  logic trig_inv,
    input  logic cts_en,
    input  logic cts_in,
    input  logic cts_inv,
    output logic en
);
    logic trig_eff;
    logic cts_ok;

    always_comb begin
        trig_eff = effective_level(trig_in, trig_inv);
        cts_ok   = !cts_en || effective_level(cts_in, cts_inv);
        en       = trig_eff && cts_ok;
    end
endmodule

// File: rtl/dbt_half_div.sv
module dbt_half_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         running,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    always_comb tick = running && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load || tick) begin
            cnt_q <= reload;
        end else if (running) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dbt_frame_seq.sv
module dbt_frame_seq
    import dbt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] bit_cnt,
    input  logic         cmp_dis,
    input  logic         start_bit_en,
    input  logic         stop_bit_en,
    input  logic         stat_clr,
    output logic         start,
    output logic         running,
    output logic         tmr_out,
    output logic         stat_flag
);
    phase_t       ph_q;
    logic         half_q;
    logic [W-1:0] hi_q;
    logic         out_q;
    logic         flag_q;
    logic         abort;
    frame_end_t   fe;

    always_comb begin
        running = (ph_q != PH_IDLE);
        start   = (ph_q == PH_IDLE) && en;
        abort   = running && cmp_dis && !en;
        fe      = '0;
        if (tick && !abort) begin
            unique case (ph_q)
                PH_DATA: begin
                    if (!cmp_dis && hi_q == '0 && !stop_bit_en) begin
                        fe.fin      = 1'b1;
                        fe.set_flag = 1'b1;
                    end
                end
                PH_STOP: begin
                    if (half_q) begin
                        fe.fin      = 1'b1;
                        fe.set_flag = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            half_q <= 1'b0;
            hi_q   <= '0;
            out_q  <= 1'b0;
        end else if (start) begin
            ph_q   <= first_phase(start_bit_en);
            half_q <= 1'b0;
            hi_q   <= bit_cnt;
            out_q  <= 1'b0;
        end else if (abort || fe.fin) begin
            ph_q   <= PH_IDLE;
            half_q <= 1'b0;
            out_q  <= 1'b0;
        end else if (tick) begin
            out_q <= !out_q;
            unique case (ph_q)
                PH_START: begin
                    if (half_q) begin
                        ph_q   <= PH_DATA;
                        half_q <= 1'b0;
                    end else begin
                        half_q <= 1'b1;
                    end
                end
                PH_DATA: begin
                    if (!cmp_dis) begin
                        if (hi_q == '0) begin
                            ph_q   <= PH_STOP;
                            half_q <= 1'b0;
                        end else begin
                            hi_q <= hi_q - 1'b1;
                        end
                    end
                end
                PH_STOP: half_q <= 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= fe.set_flag || (flag_q && !stat_clr);
    end

    always_comb begin
        tmr_out   = out_q;
        stat_flag = flag_q;
    end
endmodule

// File: rtl/dual_byte_baud_timer.sv
module dual_byte_baud_timer
    import dbt_pkg::*;
#(
    parameter int W    = CNT_W,
    localparam int CMP_W = 2 * W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             cmp_dis,
    input  logic             start_bit_en,
    input  logic             stop_bit_en,
    input  logic             trig_in,
    input  logic             trig_inv,
    input  logic             cts_en,
    input  logic             cts_in,
    input  logic             cts_inv,
    input  logic             pin_inv,
    input  logic             stat_clr,
    output logic             tmr_out,
    output logic             out_trig,
    output logic             pin_out,
    output logic             stat_flag,
    output logic             active
);
    logic en;
    logic tick;
    logic start;
    logic running;
    logic tout;

    dbt_enable_gate u_gate (
        .trig_in (trig_in),
        .trig_inv(trig_inv),
        .cts_en  (cts_en),
        .cts_in  (cts_in),
        .cts_inv (cts_inv),
        .en      (en)
    );

    dbt_half_div #(.W(W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .running(running),
        .reload (cmp_val[W-1:0]),
        .tick   (tick)
    );

    dbt_frame_seq #(.W(W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .tick        (tick),
        .bit_cnt     (cmp_val[CMP_W-1:W]),
        .cmp_dis     (cmp_dis),
        .start_bit_en(start_bit_en),
        .stop_bit_en (stop_bit_en),
        .stat_clr    (stat_clr),
        .start       (start),
        .running     (running),
        .tmr_out     (tout),
        .stat_flag   (stat_flag)
    );

    always_comb begin
        tmr_out  = tout;
        out_trig = tout;
        pin_out  = tout ^ pin_inv;
        active   = running;
    end
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker (
    input logic clk,
    input logic rst,
    input logic trig_in,
    input logic trig_inv,
    input logic cts_en,
    input logic cts_in,
    input logic cts_inv,
    input logic stat_clr,
    input logic tmr_out,
    input logic stat_flag,
    input logic active
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!active && !tmr_out && !stat_flag));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !tmr_out);

    // R5
    trig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !(trig_in ^ trig_inv)) |=> !active);

    // R6
    cts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && cts_en && !(cts_in ^ cts_inv)) |=> !active);

    // R8
    flag_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_flag) |-> $fell(active));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_flag && !stat_clr) |=> stat_flag);
endmodule

bind dual_byte_baud_timer dbt_checker u_dbt_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .trig_inv (trig_inv),
    .cts_en   (cts_en),
    .cts_in   (cts_in),
    .cts_inv  (cts_inv),
    .stat_clr (stat_clr),
    .tmr_out  (tmr_out),
    .stat_flag(stat_flag),
    .active   (active)
);

// File: tb/dual_byte_baud_timer_bench.sv
`timescale 1ns/1ps
module dual_byte_baud_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cmp_val = 16'h0F01;
    logic        cmp_dis = 1'b0;
    logic        start_bit_en = 1'b0;
    logic        stop_bit_en = 1'b0;
    logic        trig_in = 1'b0;
    logic        trig_inv = 1'b0;
    logic        cts_en = 1'b0;
    logic        cts_in = 1'b0;
    logic        cts_inv = 1'b0;
    logic        pin_inv = 1'b0;
    logic        stat_clr = 1'b0;
    logic        tmr_out, out_trig, pin_out, stat_flag, active;

    always #4 clk = !clk;

    dual_byte_baud_timer u_dual_byte_baud_timer (
        .clk(clk), .rst(rst), .cmp_val(cmp_val), .cmp_dis(cmp_dis),
        .start_bit_en(start_bit_en), .stop_bit_en(stop_bit_en),
        .trig_in(trig_in), .trig_inv(trig_inv), .cts_en(cts_en),
        .cts_in(cts_in), .cts_inv(cts_inv), .pin_inv(pin_inv),
        .stat_clr(stat_clr), .tmr_out(tmr_out), .out_trig(out_trig),
        .pin_out(pin_out), .stat_flag(stat_flag), .active(active)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: clocks left in this half, halves left in the frame
    bit m_run, m_out, m_flag;
    int m_cnt, m_halves;

    function automatic bit m_en();
        return ((trig_in ^ trig_inv) == 1'b1) && (!cts_en || ((cts_in ^ cts_inv) == 1'b1));
    endfunction

    always @(posedge clk) begin
        bit setf;
        setf = 0;
        if (rst) begin
            m_run = 0; m_out = 0; m_flag = 0; m_cnt = 0; m_halves = 0;
        end else begin
            if (!m_run) begin
                if (m_en()) begin
                    m_run = 1; m_out = 0; m_cnt = cmp_val[7:0];
                    m_halves = (cmp_val[15:8] + 1) + (start_bit_en ? 2 : 0) + (stop_bit_en ? 2 : 0);
                end
            end else if (cmp_dis && !m_en()) begin
                m_run = 0; m_out = 0;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end else begin
                m_cnt = cmp_val[7:0];
                m_out = !m_out;
                if (!cmp_dis) begin
                    m_halves--;
                    if (m_halves == 0) begin
                        m_run = 0; m_out = 0; setf = 1;
                    end
                end
            end
            m_flag = setf || (m_flag && !stat_clr);
        end
    end

    // clock-by-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check({cur_req, " active"},   active,    m_run);
            check({cur_req, " tmr_out"},  tmr_out,   m_out);
            check({cur_req, " flag"},     stat_flag, m_flag);
            check("R7 out_trig", out_trig, tmr_out);
            check("R7 pin_out",  pin_out,  tmr_out ^ pin_inv);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts active clocks of the next frame
    task automatic frame_len(output int len);
        len = 0;
        while (!active) @(negedge clk);
        while (active) begin
            len++;
            @(negedge clk);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int len;
        cycles(3);
        // R1 reset values
        check("R1 out", tmr_out, 0);
        check("R1 flag", stat_flag, 0);
        check("R1 active", active, 0);
        rst = 1'b0;

        // R5 inverted trigger, buffer-empty high holds off
        cur_req = "R5";
        trig_inv = 1'b1; trig_in = 1'b1;
        cycles(6);
        check("R5 held idle", active, 0);
        // R2 R3 8-bit frame at clk/4
        cur_req = "R3";
        trig_in = 1'b0;
        @(negedge clk); trig_in = 1'b1;
        frame_len(len);
        check("R3 frame 0x0F01 length", len, 32);
        check("R8 flag after frame", stat_flag, 1);
        cycles(5);
        check("R8 flag held", stat_flag, 1);
        cur_req = "R8";
        stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
        check("R8 flag cleared", stat_flag, 0);

        // R4 start+stop, R11 trigger dropped mid-frame
        cur_req = "R4";
        trig_inv = 1'b0; start_bit_en = 1'b1; stop_bit_en = 1'b1;
        cmp_val = 16'h0702;
        trig_in = 1'b1; @(negedge clk);
        cycles(5);
        trig_in = 1'b0;
        while (active) @(negedge clk);
        check("R11 frame not cut", stat_flag, 1);
        trig_in = 1'b1;
        frame_len(len);
        check("R4 start+stop length", len, 36);
        trig_in = 1'b0;
        start_bit_en = 1'b0;
        trig_in = 1'b1;
        frame_len(len);
        check("R4 stop only length", len, 30);
        trig_in = 1'b0;

        // R2 single-clock half period
        cur_req = "R2";
        stop_bit_en = 1'b0; cmp_val = 16'h0300;
        trig_in = 1'b1;
        frame_len(len);
        check("R2 lo=0 length", len, 4);

        // R9 back-to-back restart with trigger held
        cur_req = "R9";
        @(negedge clk);
        check("R9 restarted", active, 1);
        trig_in = 1'b0;
        while (active) @(negedge clk);

        // R6 CTS gating with active-low pin
        cur_req = "R6";
        cts_en = 1'b1; cts_inv = 1'b1; cts_in = 1'b1; pin_inv = 1'b1;
        cmp_val = 16'h0F01;
        trig_in = 1'b1;
        cycles(6);
        check("R6 CTS holds off", active, 0);
        cts_in = 1'b0;
        frame_len(len);
        check("R6 CTS released length", len, 32);
        trig_in = 1'b0;
        cts_en = 1'b0; cts_in = 1'b1;
        cycles(2);

        // R10 compare disabled
        cur_req = "R10";
        stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
        cmp_dis = 1'b1; cmp_val = 16'h0001;
        trig_in = 1'b1;
        cycles(50);
        check("R10 still running", active, 1);
        trig_in = 1'b0;
        cycles(2);
        check("R10 stopped", active, 0);
        check("R10 no flag", stat_flag, 0);
        cmp_dis = 1'b0;
        cycles(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule